// File: doc/BRIEF.md
# Sixteen-Line DMA Serial Transmitter

This block drives sixteen asynchronous serial output lines from one shared transmit engine. Software arms a line by giving it a buffer address and a character count. That sets the line's bit in a buffer-active bitmap. A round-robin arbiter picks an armed line whose shift register is idle. The engine then reads one byte for that line through a simple memory read port, hands the byte to the line's shift register, advances the line's address and lowers its remaining count.

Every line uses the same frame settings, which come from static configuration inputs. These are the number of data bits (5 to 8), the number of stop bits (1 or 2) and the bit time in clock cycles. The divisor is chosen so that the bit rate lands between 50 and 1200 baud.

When a line's last character has been fetched, its active bit drops and a dedicated transmit interrupt rises. The interrupt stays high until it is acknowledged. Any line can be forced into a break, in which its output is held at the space level.

Top module: `mdt_top`

## Requirements
- R1: After reset every txd bit is 1, line_active is all zeros, tx_irq is 0 and mem_req is 0.
- R2: A start_valid with a nonzero start_len sets line_active for start_line and loads that line's address and count. A start with start_len of zero, or a start aimed at a line that is already active, changes nothing.
- R3: Each fetch for a line reads from that line's current address. Successive fetches read consecutive addresses, and exactly start_len characters are fetched and sent.
- R4: Each frame is sent in this order: a start bit of 0, then 5+cfg_bits data bits with the least significant bit first, then one stop bit of 1, or two when cfg_two_stop is 1. Every bit lasts cfg_div clock cycles, and data bits above the selected length are not sent.
- R5: A line that is not sending and not in break rests at 1.
- R6: mem_req is a one-cycle pulse. No new request is issued until mem_rvalid answers the previous one.
- R7: Among the lines that are active and idle, the next one served is the first found when scanning upward, with wraparound, from the line after the one served last.
- R8: A line's active bit clears when its last character is fetched. tx_irq rises the cycle after any active bit clears and stays high until irq_ack.
- R9: While brk[i] is 1, txd[i] is 0. Other lines are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 16 | Clock cycles per bit (at least 2) |
| cfg_bits | input | 2 | Data bits minus five |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| start_valid | input | 1 | Arm a line |
| start_line | input | 4 | Line to arm |
| start_addr | input | 16 | First buffer address |
| start_len | input | 12 | Number of characters |
| brk | input | 16 | Per-line break force |
| irq_ack | input | 1 | Clears tx_irq |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 16 | Read address |
| mem_rvalid | input | 1 | One-cycle read data valid |
| mem_rdata | input | 8 | Read data |
| txd | output | 16 | Serial outputs |
| line_active | output | 16 | Buffer-active bitmap |
| tx_irq | output | 1 | Transmit completion interrupt |

## Verification
The round-robin order is the hardest behaviour to reach from the ports. Normally the engine grants a line within one cycle of it being armed, so several lines are rarely eligible at the same moment. The bench's memory model withholds its response to a first request. While that response is held, three more lines are armed in scrambled order and the bench confirms that no second request appears. It then releases the memory and checks that the next three request addresses follow the wraparound order from the line served first.

// File: rtl/mdt_pkg.sv
package mdt_pkg;
    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_WAIT = 1'b1
    } eng_st_e;
endpackage

// File: rtl/mdt_rr.sv
module mdt_rr #(
    parameter int NLINES = 16,
    localparam int LW = $clog2(NLINES)
) (
    input  logic [NLINES-1:0] elig,
    input  logic [LW-1:0]     last,
    output logic              gnt_valid,
    output logic [LW-1:0]     gnt_idx
);
    always_comb begin
        int unsigned idx;
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 1; k <= NLINES; k++) begin
            idx = (int'(last) + k) % NLINES;
            if (!gnt_valid && elig[idx]) begin
                gnt_valid = 1'b1;
                gnt_idx   = LW'(idx);
            end
        end
    end
endmodule

// File: rtl/mdt_line_tx.sv
module mdt_line_tx #(
    parameter int DIVW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [7:0]      data,
    input  logic [1:0]      cfg_bits,
    input  logic            cfg_two_stop,
    input  logic [DIVW-1:0] cfg_div,
    output logic            serial,
    output logic            busy
);
    typedef struct packed {
        logic [10:0]     sh;
        logic [3:0]      cnt;
        logic [DIVW-1:0] tmr;
    } ltx_t;

    ltx_t q, d;
    logic [7:0] masked;

    always_comb begin
        for (int k = 0; k < 8; k++)
            masked[k] = (k < 5 + int'(cfg_bits)) ? data[k] : 1'b1;
    end

    always_comb begin
        d = q;
        if (load) begin
            d.sh  = {2'b11, masked, 1'b0};
            d.cnt = 4'd7 + {2'b00, cfg_bits} + {3'b000, cfg_two_stop};
            d.tmr = cfg_div - DIVW'(1);
        end else if (q.cnt != 4'd0) begin
            if (q.tmr == '0) begin
                d.sh  = {1'b1, q.sh[10:1]};
                d.cnt = q.cnt - 4'd1;
                d.tmr = cfg_div - DIVW'(1);
            end else begin
                d.tmr = q.tmr - DIVW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy   = (q.cnt != 4'd0);
    assign serial = busy ? q.sh[0] : 1'b1;

    a_r4_start_space: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !serial);
    a_r4_last_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == 4'd1) |-> serial);
endmodule

// File: rtl/mdt_top.sv
module mdt_top #(
    parameter int NLINES = 16,
    parameter int AW     = 16,
    parameter int LENW   = 12,
    parameter int DIVW   = 16,
    localparam int LW    = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIVW-1:0]   cfg_div,
    input  logic [1:0]        cfg_bits,
    input  logic              cfg_two_stop,
    input  logic              start_valid,
    input  logic [LW-1:0]     start_line,
    input  logic [AW-1:0]     start_addr,
    input  logic [LENW-1:0]   start_len,
    input  logic [NLINES-1:0] brk,
    input  logic              irq_ack,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    output logic [NLINES-1:0] txd,
    output logic [NLINES-1:0] line_active,
    output logic              tx_irq
);
    import mdt_pkg::*;

    typedef struct packed {
        eng_st_e                       st;
        logic                          req;
        logic [LW-1:0]                 cur;
        logic [LW-1:0]                 last;
        logic [AW-1:0]                 raddr;
        logic [NLINES-1:0]             act;
        logic [NLINES-1:0][AW-1:0]     addr;
        logic [NLINES-1:0][LENW-1:0]   left;
        logic                          irq;
    } eng_t;

    eng_t q, d;
    logic [NLINES-1:0] busy, ser, ld_vec, elig;
    logic              gnt_valid;
    logic [LW-1:0]     gnt_idx;

    assign elig = q.act & ~busy;

    mdt_rr #(.NLINES(NLINES)) u_rr (
        .elig      (elig),
        .last      (q.last),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    always_comb begin
        d      = q;
        d.req  = 1'b0;
        ld_vec = '0;
        if (start_valid && !q.act[start_line] && start_len != '0) begin
            d.act[start_line]  = 1'b1;
            d.addr[start_line] = start_addr;
            d.left[start_line] = start_len;
        end
        case (q.st)
            ENG_IDLE: if (gnt_valid) begin
                d.st    = ENG_WAIT;
                d.req   = 1'b1;
                d.cur   = gnt_idx;
                d.last  = gnt_idx;
                d.raddr = q.addr[gnt_idx];
            end
            ENG_WAIT: if (mem_rvalid) begin
                d.st           = ENG_IDLE;
                ld_vec[q.cur]  = 1'b1;
                d.addr[q.cur]  = q.addr[q.cur] + AW'(1);
                d.left[q.cur]  = q.left[q.cur] - LENW'(1);
                if (q.left[q.cur] == LENW'(1)) d.act[q.cur] = 1'b0;
            end
            default: d.st = ENG_IDLE;
        endcase
        if (irq_ack) d.irq = 1'b0;
        if (|(q.act & ~d.act)) d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.last <= LW'(NLINES - 1);
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        mdt_line_tx #(.DIVW(DIVW)) u_tx (
            .clk          (clk),
            .rst_n        (rst_n),
            .load         (ld_vec[g]),
            .data         (mem_rdata),
            .cfg_bits     (cfg_bits),
            .cfg_two_stop (cfg_two_stop),
            .cfg_div      (cfg_div),
            .serial       (ser[g]),
            .busy         (busy[g])
        );
        assign txd[g] = brk[g] ? 1'b0 : ser[g];
    end

    assign mem_req     = q.req;
    assign mem_addr    = q.raddr;
    assign line_active = q.act;
    assign tx_irq      = q.irq;

    a_r6_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    a_r7_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (q.act[gnt_idx] && !busy[gnt_idx]));
    a_r3_load_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_vec & busy) == '0);
    a_r8_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(line_active) & ~line_active)) |-> tx_irq);
    a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && !irq_ack) |=> tx_irq);
endmodule

// File: tb/mdt_top_test.sv
module mdt_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_div = 16'd8;
    logic [1:0]  cfg_bits = 2'd3;
    logic        cfg_two_stop = 1'b0;
    logic        start_valid = 1'b0;
    logic [3:0]  start_line = '0;
    logic [15:0] start_addr = '0;
    logic [11:0] start_len = '0;
    logic [15:0] brk = '0;
    logic        irq_ack = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid;
    logic [7:0]  mem_rdata;
    logic [15:0] txd, line_active;
    logic        tx_irq;

    int tests = 0, fails = 0;
    int n_req = 0;
    logic [15:0] req_log [0:63];
    logic hold = 1'b0;
    logic pend = 1'b0;
    logic [15:0] paddr = '0;
    bit done = 0;

    always #2 clk = ~clk;

    mdt_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_bits(cfg_bits),
        .cfg_two_stop(cfg_two_stop), .start_valid(start_valid),
        .start_line(start_line), .start_addr(start_addr), .start_len(start_len),
        .brk(brk), .irq_ack(irq_ack), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .txd(txd),
        .line_active(line_active), .tx_irq(tx_irq)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ 8'h5A ^ {a[11:8], 4'h0};
    endfunction

    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (mem_req) begin
                if (n_req < 64) req_log[n_req] = mem_addr;
                n_req++;
                pend  = 1'b1;
                paddr = mem_addr;
            end else if (pend && !hold) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem_byte(paddr);
                pend       = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic arm(input int line, input logic [15:0] a, input int len);
        @(negedge clk);
        start_valid = 1'b1;
        start_line  = 4'(line);
        start_addr  = a;
        start_len   = 12'(len);
        @(negedge clk);
        start_valid = 1'b0;
    endtask

    task automatic wait_fall(input int line);
        int n = 0;
        while (txd[line] !== 1'b0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_frame(input int line, input logic [7:0] b, input string req);
        int nb = 5 + int'(cfg_bits);
        int ns = cfg_two_stop ? 2 : 1;
        logic [11:0] exp = '1;
        logic [11:0] got = '1;
        exp[0] = 1'b0;
        for (int k = 0; k < nb; k++) exp[k+1] = b[k];
        wait_fall(line);
        repeat (int'(cfg_div) / 2) @(negedge clk);
        for (int k = 0; k < 1 + nb + ns; k++) begin
            got[k] = txd[line];
            if (k < nb + ns) repeat (int'(cfg_div)) @(negedge clk);
        end
        chk(got == exp, req, got, exp);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_req = 0;
    endtask

    task automatic t_reset;
        chk(txd == 16'hFFFF, "R1 txd", txd, 16'hFFFF);
        chk(line_active == 0, "R1 active", line_active, 0);
        chk(tx_irq == 0, "R1 irq", tx_irq, 0);
        chk(mem_req == 0, "R1 req", mem_req, 0);
    endtask

    task automatic t_basic_frame;
        cfg_bits = 2'd3; cfg_two_stop = 1'b0;
        arm(4, 16'h0040, 1);
        check_frame(4, mem_byte(16'h0040), "R4 8N1 frame");
        chk(n_req == 1 && req_log[0] == 16'h0040, "R3 address", req_log[0], 16'h0040);
        chk(line_active[4] == 0, "R8 active cleared", line_active[4], 0);
        chk(tx_irq == 1, "R8 irq raised", tx_irq, 1);
        repeat (5) @(negedge clk);
        chk(tx_irq == 1, "R8 irq held", tx_irq, 1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0; @(negedge clk);
        chk(tx_irq == 0, "R8 irq acked", tx_irq, 0);
        repeat (10) @(negedge clk);
        chk(txd[4] == 1, "R5 idle mark", txd[4], 1);
    endtask

    task automatic t_short_two_stop;
        cfg_bits = 2'd0; cfg_two_stop = 1'b1;
        arm(0, 16'h0123, 1);
        check_frame(0, mem_byte(16'h0123), "R4 5-bit 2-stop frame");
        repeat (int'(cfg_div)) @(negedge clk);
        chk(txd[0] == 1, "R5 idle after frame", txd[0], 1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        cfg_bits = 2'd3; cfg_two_stop = 1'b0;
    endtask

    task automatic t_multi_char;
        int base = n_req;
        cfg_bits = 2'd2;
        arm(15, 16'h01F0, 3);
        for (int c = 0; c < 3; c++)
            check_frame(15, mem_byte(16'h01F0 + 16'(c)), "R3 multi-char frame");
        chk(n_req - base == 3, "R3 fetch count", n_req - base, 3);
        chk(req_log[base+2] == 16'h01F2, "R3 address step", req_log[base+2], 16'h01F2);
        chk(line_active[15] == 0, "R8 active after last", line_active[15], 0);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        cfg_bits = 2'd3;
    endtask

    task automatic t_ignore_start;
        int base;
        arm(7, 16'h0700, 0);
        repeat (5) @(negedge clk);
        chk(line_active[7] == 0, "R2 zero length ignored", line_active[7], 0);
        base = n_req;
        hold = 1'b1;
        arm(3, 16'h0300, 2);
        repeat (3) @(negedge clk);
        arm(3, 16'h5000, 4);
        hold = 1'b0;
        check_frame(3, mem_byte(16'h0300), "R2 first frame");
        check_frame(3, mem_byte(16'h0301), "R2 second frame");
        chk(req_log[base+1] == 16'h0301, "R2 restart ignored", req_log[base+1], 16'h0301);
        chk(n_req - base == 2, "R2 count unchanged", n_req - base, 2);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic t_round_robin;
        int base = n_req;
        hold = 1'b1;
        arm(9, 16'h0900, 1);
        repeat (3) @(negedge clk);
        arm(2, 16'h0200, 1);
        arm(14, 16'h0E00, 1);
        arm(11, 16'h0B00, 1);
        repeat (20) @(negedge clk);
        chk(n_req - base == 1, "R6 one outstanding", n_req - base, 1);
        hold = 1'b0;
        repeat (40) @(negedge clk);
        chk(req_log[base+1] == 16'h0B00, "R7 first after 9", req_log[base+1], 16'h0B00);
        chk(req_log[base+2] == 16'h0E00, "R7 second", req_log[base+2], 16'h0E00);
        chk(req_log[base+3] == 16'h0200, "R7 wraparound", req_log[base+3], 16'h0200);
        repeat (150) @(negedge clk);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic t_break;
        brk[6] = 1'b1;
        repeat (4) @(negedge clk);
        chk(txd[6] == 0, "R9 break space", txd[6], 0);
        chk(txd[5] == 1, "R9 neighbour mark", txd[5], 1);
        repeat (30) @(negedge clk);
        chk(txd[6] == 0, "R9 break held", txd[6], 0);
        brk[6] = 1'b0;
        @(negedge clk);
        chk(txd[6] == 1, "R9 break released", txd[6], 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        t_basic_frame();
        t_short_two_stop();
        t_multi_char();
        t_ignore_start();
        t_round_robin();
        t_break();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule